// File: doc/BRIEF.md
# Register-Pair Doubleword Load/Store Unit

This execution block lets a 32-bit core move a 64-bit value between data memory and an even/odd register pair with a single instruction. It receives already-split instruction fields and reads three register file ports combinationally in the issue cycle. It then runs two word-sized accesses on a 32-bit request/acknowledge memory port. The first access uses the effective address and carries the even register. The second uses the effective address plus 4 and carries the odd register.

For loads, both returned words are written back together through a pair write port. This happens only after the second access has completed without error. Encodings that cannot run raise a one-cycle illegal pulse. Word-misaligned addresses raise a misaligned pulse. An error response on either access raises a fault pulse. None of these three cases writes a register. Instructions that do not match the paired opcodes are ignored, so other units can decode them.

Top module: `pairls_unit`

## Requirements
- R1: An issue with opcode 7'b0000011 and funct3 3'b011 is a paired load. It reads the word at the effective address and then the word at the effective address plus 4. After the second read it writes the first word to register rd and the second to rd+1, with wb_idx = rd.
- R2: An issue with opcode 7'b0100011 and funct3 3'b011 is a paired store. It writes register rs2 to the effective address and then register rs2+1 to the effective address plus 4.
- R3: When feature_en is low, or when the IS_RV32 parameter is 0, a paired encoding produces flag_illegal for one cycle and makes no memory request.
- R4: An odd rd on a paired load, or an odd rs2 on a paired store, produces flag_illegal and makes no memory request.
- R5: The effective address is the rs1 value plus the 12-bit immediate sign-extended to 32 bits. This includes negative immediates.
- R6: A paired load with rd = 0 still performs both reads but makes no register write.
- R7: A paired store with rs2 = 0 writes zero in both words, whatever the odd partner register holds.
- R8: An effective address with bits [1:0] non-zero produces flag_misaligned and makes no memory request. Illegal takes priority over misaligned.
- R9: An error response on either access ends the instruction with flag_fault and no register write. A load's register pair is written only after a clean second response.
- R10: busy is high from the cycle after acceptance until the final acknowledge. Issues presented while busy is high are ignored. After reset, busy, mem_req and wb_en are low.
- R11: Issues with any other opcode/funct3 combination produce no flag, no request and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feature_en | input | 1 | Enables the paired operations |
| issue_valid | input | 1 | Instruction fields valid this cycle |
| issue_opcode | input | 7 | Major opcode |
| issue_funct3 | input | 3 | Minor opcode |
| issue_rd | input | 5 | Destination register index |
| issue_rs1 | input | 5 | Base register index |
| issue_rs2 | input | 5 | Store source register index |
| issue_imm | input | 12 | Raw immediate, sign-extended internally |
| rf_ra_base | output | 5 | Read address for the base register |
| rf_ra_lo | output | 5 | Read address for the even store register |
| rf_ra_hi | output | 5 | Read address for the odd store register |
| rf_rd_base | input | 32 | Base register value |
| rf_rd_lo | input | 32 | Even store register value |
| rf_rd_hi | input | 32 | Odd store register value |
| busy | output | 1 | Instruction in flight |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete this cycle |
| mem_err | input | 1 | Access failed, valid with mem_ack |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| wb_en | output | 1 | Pair write strobe |
| wb_idx | output | 5 | Even register of the pair |
| wb_lo | output | 32 | Value for the even register |
| wb_hi | output | 32 | Value for the odd register |
| flag_illegal | output | 1 | Illegal-instruction pulse |
| flag_misaligned | output | 1 | Misaligned-address pulse |
| flag_fault | output | 1 | Access-fault pulse |
| op_done | output | 1 | Instruction completed cleanly |

## Verification
The illegal and misaligned pulses are due in the cycle after the issue edge. The first request appears in that same cycle. The address for the second access appears in the cycle after the first acknowledge. The pair write or fault pulse is due in the cycle after the second acknowledge, or after the first acknowledge when that one errs.

Results depend on the memory's acknowledge timing, not on a fixed latency. The bench therefore samples on the falling edge and matches every event the block emits against an ordered queue of expected events. Any event arriving early, late, out of order or unexpectedly is a miscompare. A queue that is not empty once the block goes idle is also a miscompare.

// File: rtl/pairls_pkg.sv
package pairls_pkg;
  localparam int CORE_W = 32;
  localparam int RIDX_W = 5;

  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [2:0] F3_PAIR   = 3'b011;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } beat_st_e;

  typedef struct packed {
    logic              is_store;
    logic [RIDX_W-1:0] pair_rd;
    logic [CORE_W-1:0] ea;
    logic [CORE_W-1:0] wlo;
    logic [CORE_W-1:0] whi;
  } pair_cmd_t;
endpackage

// File: rtl/pairls_stsrc.sv
module pairls_stsrc #(
  parameter int XW = 32,
  parameter int RW = 5
) (
  input  logic [RW-1:0] src_idx,
  input  logic [XW-1:0] src_lo,
  input  logic [XW-1:0] src_hi,
  output logic [XW-1:0] out_lo,
  output logic [XW-1:0] out_hi
);
  logic is_zero_pair;
  assign is_zero_pair = (src_idx == '0);
  // x0 as source means a 64-bit zero, not x0 joined with x1
  assign out_lo = is_zero_pair ? '0 : src_lo;
  assign out_hi = is_zero_pair ? '0 : src_hi;
endmodule

// File: rtl/pairls_decode.sv
module pairls_decode
  import pairls_pkg::*;
#(
  parameter bit IS_RV32 = 1'b1,
  parameter int XW      = 32,
  parameter int IMM_W   = 12,
  parameter int RW      = 5
) (
  input  logic            valid,
  input  logic            feature_en,
  input  logic [6:0]      opcode,
  input  logic [2:0]      funct3,
  input  logic [RW-1:0]   rd,
  input  logic [RW-1:0]   rs2,
  input  logic [IMM_W-1:0] imm,
  input  logic [XW-1:0]   base_val,
  input  logic [XW-1:0]   wlo,
  input  logic [XW-1:0]   whi,
  output logic            hit,
  output logic            illegal,
  output logic            misaligned,
  output pair_cmd_t       cmd
);
  localparam int EXT_W = XW - IMM_W;

  logic is_ld, is_st, cfg_ok;
  logic [RW-1:0] pair_reg;
  logic [XW-1:0] ea;

  generate
    if (IS_RV32) begin : g_rv32
      assign cfg_ok = feature_en;
    end else begin : g_wide
      assign cfg_ok = 1'b0;
    end
  endgenerate

  assign is_ld    = (opcode == OPC_LOAD)  && (funct3 == F3_PAIR);
  assign is_st    = (opcode == OPC_STORE) && (funct3 == F3_PAIR);
  assign hit      = valid && (is_ld || is_st);
  assign pair_reg = is_st ? rs2 : rd;
  assign ea       = base_val + {{EXT_W{imm[IMM_W-1]}}, imm};

  assign illegal    = hit && (!cfg_ok || pair_reg[0]);
  assign misaligned = hit && !illegal && (ea[1:0] != 2'b00);

  always_comb begin
    cmd          = '0;
    cmd.is_store = is_st;
    cmd.pair_rd  = pair_reg;
    cmd.ea       = ea;
    cmd.wlo      = wlo;
    cmd.whi      = whi;
  end
endmodule

// File: rtl/pairls_seq.sv
module pairls_seq
  import pairls_pkg::*;
#(
  parameter int XW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          illegal,
  input  logic          misaligned,
  input  pair_cmd_t     cmd,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [XW-1:0] mem_rdata,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [XW-1:0] mem_addr,
  output logic [XW-1:0] mem_wdata,
  output logic          wb_en,
  output logic [RW-1:0] wb_idx,
  output logic [XW-1:0] wb_lo,
  output logic [XW-1:0] wb_hi,
  output logic          flag_ill,
  output logic          flag_mis,
  output logic          flag_flt,
  output logic          done
);
  localparam logic [XW-1:0] WORD_STEP = XW'(4);

  beat_st_e      state;
  pair_cmd_t     cmd_q;
  logic [XW-1:0] lo_cap;

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cmd_q     <= '0;
      lo_cap    <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      wb_en     <= 1'b0;
      wb_idx    <= '0;
      wb_lo     <= '0;
      wb_hi     <= '0;
      flag_ill  <= 1'b0;
      flag_mis  <= 1'b0;
      flag_flt  <= 1'b0;
      done      <= 1'b0;
    end else begin
      wb_en    <= 1'b0;
      flag_ill <= 1'b0;
      flag_mis <= 1'b0;
      flag_flt <= 1'b0;
      done     <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (hit) begin
            if (illegal) begin
              flag_ill <= 1'b1;
            end else if (misaligned) begin
              flag_mis <= 1'b1;
            end else begin
              cmd_q     <= cmd;
              state     <= ST_LO;
              mem_req   <= 1'b1;
              mem_we    <= cmd.is_store;
              mem_addr  <= cmd.ea;
              mem_wdata <= cmd.wlo;
            end
          end
        end
        ST_LO: begin
          if (mem_ack) begin
            if (mem_err) begin
              flag_flt <= 1'b1;
              mem_req  <= 1'b0;
              state    <= ST_IDLE;
            end else begin
              lo_cap    <= mem_rdata;
              mem_addr  <= cmd_q.ea + WORD_STEP;
              mem_wdata <= cmd_q.whi;
              state     <= ST_HI;
            end
          end
        end
        ST_HI: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            state   <= ST_IDLE;
            if (mem_err) begin
              flag_flt <= 1'b1;
            end else begin
              done <= 1'b1;
              if (!cmd_q.is_store && (cmd_q.pair_rd != '0)) begin
                wb_en  <= 1'b1;
                wb_idx <= cmd_q.pair_rd;
                wb_lo  <= lo_cap;
                wb_hi  <= mem_rdata;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  req_inside_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R9
  commit_after_last_beat_chk: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (!busy && !mem_req));

  // R3
  flag_without_request_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_ill || flag_mis) |-> !mem_req);

  // R9
  single_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flag_ill, flag_mis, flag_flt, done}));

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> $stable(mem_addr));
endmodule

// File: rtl/pairls_unit.sv
module pairls_unit
  import pairls_pkg::*;
#(
  parameter bit IS_RV32 = 1'b1,
  parameter int XW      = CORE_W,
  parameter int IMM_W   = 12,
  parameter int RW      = RIDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             feature_en,
  input  logic             issue_valid,
  input  logic [6:0]       issue_opcode,
  input  logic [2:0]       issue_funct3,
  input  logic [RW-1:0]    issue_rd,
  input  logic [RW-1:0]    issue_rs1,
  input  logic [RW-1:0]    issue_rs2,
  input  logic [IMM_W-1:0] issue_imm,
  output logic [RW-1:0]    rf_ra_base,
  output logic [RW-1:0]    rf_ra_lo,
  output logic [RW-1:0]    rf_ra_hi,
  input  logic [XW-1:0]    rf_rd_base,
  input  logic [XW-1:0]    rf_rd_lo,
  input  logic [XW-1:0]    rf_rd_hi,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [XW-1:0]    mem_addr,
  output logic [XW-1:0]    mem_wdata,
  input  logic             mem_ack,
  input  logic             mem_err,
  input  logic [XW-1:0]    mem_rdata,
  output logic             wb_en,
  output logic [RW-1:0]    wb_idx,
  output logic [XW-1:0]    wb_lo,
  output logic [XW-1:0]    wb_hi,
  output logic             flag_illegal,
  output logic             flag_misaligned,
  output logic             flag_fault,
  output logic             op_done
);
  logic      dec_hit, dec_ill, dec_mis;
  logic [XW-1:0] st_lo, st_hi;
  pair_cmd_t dec_cmd;

  assign rf_ra_base = issue_rs1;
  assign rf_ra_lo   = issue_rs2;
  assign rf_ra_hi   = {issue_rs2[RW-1:1], 1'b1};

  pairls_stsrc #(.XW(XW), .RW(RW)) u_stsrc (
    .src_idx (issue_rs2),
    .src_lo  (rf_rd_lo),
    .src_hi  (rf_rd_hi),
    .out_lo  (st_lo),
    .out_hi  (st_hi)
  );

  pairls_decode #(.IS_RV32(IS_RV32), .XW(XW), .IMM_W(IMM_W), .RW(RW)) u_dec (
    .valid      (issue_valid),
    .feature_en (feature_en),
    .opcode     (issue_opcode),
    .funct3     (issue_funct3),
    .rd         (issue_rd),
    .rs2        (issue_rs2),
    .imm        (issue_imm),
    .base_val   (rf_rd_base),
    .wlo        (st_lo),
    .whi        (st_hi),
    .hit        (dec_hit),
    .illegal    (dec_ill),
    .misaligned (dec_mis),
    .cmd        (dec_cmd)
  );

  pairls_seq #(.XW(XW), .RW(RW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .hit        (dec_hit),
    .illegal    (dec_ill),
    .misaligned (dec_mis),
    .cmd        (dec_cmd),
    .mem_ack    (mem_ack),
    .mem_err    (mem_err),
    .mem_rdata  (mem_rdata),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .wb_en      (wb_en),
    .wb_idx     (wb_idx),
    .wb_lo      (wb_lo),
    .wb_hi      (wb_hi),
    .flag_ill   (flag_illegal),
    .flag_mis   (flag_misaligned),
    .flag_flt   (flag_fault),
    .done       (op_done)
  );
endmodule

// File: tb/pairls_unit_test.sv
`timescale 1ns/1ps
module pairls_unit_test;
  localparam int K_RD = 0, K_WR = 1, K_WB = 2, K_ILL = 3, K_MIS = 4, K_FLT = 5;

  typedef struct {
    int          kind;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] c;
    string       tag;
  } ev_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic feature_en = 1'b1;
  logic issue_valid = 1'b0;
  logic [6:0]  issue_opcode = '0;
  logic [2:0]  issue_funct3 = '0;
  logic [4:0]  issue_rd = '0, issue_rs1 = '0, issue_rs2 = '0;
  logic [11:0] issue_imm = '0;
  logic [4:0]  rf_ra_base, rf_ra_lo, rf_ra_hi;
  logic [31:0] rf_rd_base, rf_rd_lo, rf_rd_hi;
  logic busy, mem_req, mem_we, wb_en, flag_illegal, flag_misaligned, flag_fault, op_done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, wb_lo, wb_hi;
  logic [4:0]  wb_idx;
  logic mem_ack, mem_err;

  logic [31:0] rf [32];
  logic [31:0] mem [64];
  ev_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pairls_unit uut (
    .clk(clk), .rst(rst), .feature_en(feature_en), .issue_valid(issue_valid),
    .issue_opcode(issue_opcode), .issue_funct3(issue_funct3), .issue_rd(issue_rd),
    .issue_rs1(issue_rs1), .issue_rs2(issue_rs2), .issue_imm(issue_imm),
    .rf_ra_base(rf_ra_base), .rf_ra_lo(rf_ra_lo), .rf_ra_hi(rf_ra_hi),
    .rf_rd_base(rf_rd_base), .rf_rd_lo(rf_rd_lo), .rf_rd_hi(rf_rd_hi),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_lo(wb_lo), .wb_hi(wb_hi),
    .flag_illegal(flag_illegal), .flag_misaligned(flag_misaligned),
    .flag_fault(flag_fault), .op_done(op_done)
  );

  assign rf_rd_base = rf[rf_ra_base];
  assign rf_rd_lo   = rf[rf_ra_lo];
  assign rf_rd_hi   = rf[rf_ra_hi];
  assign mem_rdata  = mem[mem_addr[7:2]];
  assign mem_err    = (mem_addr[31:28] == 4'hF);

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 32'h0101_0101 * i;
    rf[0] = 32'h0;
    rf[1] = 32'h0000_0040;
    rf[2] = 32'hEFFF_FFF0;
    rf[3] = 32'h0000_0042;
    rf[4] = 32'hAAAA_0004;
    rf[5] = 32'hBBBB_0005;
    for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE_0000 | i;
  end

  // memory model: acknowledges every other cycle while a request is held
  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else     mem_ack <= mem_req && !mem_ack;
    if (mem_req && mem_we && mem_ack && !mem_err) mem[mem_addr[7:2]] <= mem_wdata;
    if (wb_en) begin
      rf[wb_idx]                 <= wb_lo;
      rf[{wb_idx[4:1], 1'b1}]    <= wb_hi;
    end
  end

  function automatic void push(int k, logic [31:0] a, logic [31:0] b, logic [31:0] c, string tag);
    ev_t e;
    e.kind = k; e.a = a; e.b = b; e.c = c; e.tag = tag;
    exp_q.push_back(e);
  endfunction

  task automatic observe(int k, logic [31:0] a, logic [31:0] b, logic [31:0] c);
    ev_t e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL unexpected event: actual kind=%0d a=%h b=%h c=%h expected none", k, a, b, c);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != k || e.a != a || e.b != b || e.c != c) begin
        n_fail++;
        $display("FAIL %s: actual kind=%0d a=%h b=%h c=%h expected kind=%0d a=%h b=%h c=%h",
                 e.tag, k, a, b, c, e.kind, e.a, e.b, e.c);
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req && mem_ack) begin
        if (mem_we) observe(K_WR, mem_addr, mem_wdata, 32'h0);
        else        observe(K_RD, mem_addr, 32'h0, 32'h0);
      end
      if (wb_en)           observe(K_WB, {27'h0, wb_idx}, wb_lo, wb_hi);
      if (flag_illegal)    observe(K_ILL, 32'h0, 32'h0, 32'h0);
      if (flag_misaligned) observe(K_MIS, 32'h0, 32'h0, 32'h0);
      if (flag_fault)      observe(K_FLT, 32'h0, 32'h0, 32'h0);
    end
  end

  task automatic settle(string tag);
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s: actual %0d events outstanding expected 0", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic drive(logic [6:0] opc, logic [2:0] f3, logic [4:0] rd, logic [4:0] rs1,
                       logic [4:0] rs2, logic [11:0] imm, bit intrude);
    while (busy) @(negedge clk);
    issue_opcode = opc; issue_funct3 = f3; issue_rd = rd;
    issue_rs1 = rs1; issue_rs2 = rs2; issue_imm = imm; issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
    if (intrude) begin
      // R10: odd-register paired load while busy must be dropped
      issue_opcode = 7'b0000011; issue_funct3 = 3'b011; issue_rd = 5'd9; issue_valid = 1'b1;
      @(negedge clk);
      issue_valid = 1'b0;
    end
  endtask

  task automatic do_op(bit is_st, logic [4:0] r, logic [4:0] rs1, logic [11:0] imm,
                       bit en, bit intrude, string tag);
    logic [31:0] ea, lo, hi;
    feature_en = en;
    ea = rf[rs1] + {{20{imm[11]}}, imm};
    if (!en || r[0]) begin
      push(K_ILL, 0, 0, 0, tag);
    end else if (ea[1:0] != 2'b00) begin
      push(K_MIS, 0, 0, 0, tag);
    end else if (!is_st) begin
      push(K_RD, ea, 0, 0, tag);
      if (ea[31:28] == 4'hF) push(K_FLT, 0, 0, 0, tag);
      else begin
        push(K_RD, ea + 4, 0, 0, tag);
        if ((ea + 32'd4) >> 28 == 32'hF) push(K_FLT, 0, 0, 0, tag);
        else if (r != 0) push(K_WB, {27'h0, r}, mem[ea[7:2]], mem[(ea[7:2] + 6'd1)], tag);
      end
    end else begin
      lo = (r == 0) ? 32'h0 : rf[r];
      hi = (r == 0) ? 32'h0 : rf[{r[4:1], 1'b1}];
      push(K_WR, ea, lo, 0, tag);
      if (ea[31:28] == 4'hF) push(K_FLT, 0, 0, 0, tag);
      else begin
        push(K_WR, ea + 4, hi, 0, tag);
        if ((ea + 32'd4) >> 28 == 32'hF) push(K_FLT, 0, 0, 0, tag);
      end
    end
    if (is_st) drive(7'b0100011, 3'b011, 5'd0, rs1, r, imm, intrude);
    else       drive(7'b0000011, 3'b011, r, rs1, 5'd0, imm, intrude);
    settle(tag);
    feature_en = 1'b1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (busy !== 1'b0 || mem_req !== 1'b0 || wb_en !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset: actual busy=%b req=%b wb=%b expected 0 0 0", busy, mem_req, wb_en);
    end
    rst = 1'b0;
    @(negedge clk);

    do_op(1'b0, 5'd8,  5'd1, 12'h008, 1'b1, 1'b0, "R1 paired load");
    do_op(1'b0, 5'd10, 5'd1, 12'hFF0, 1'b1, 1'b0, "R5 negative immediate");
    do_op(1'b1, 5'd4,  5'd1, 12'h020, 1'b1, 1'b0, "R2 paired store");
    do_op(1'b0, 5'd12, 5'd1, 12'h020, 1'b1, 1'b0, "R2 store readback");
    do_op(1'b1, 5'd0,  5'd1, 12'h010, 1'b1, 1'b0, "R7 x0 store");
    do_op(1'b0, 5'd14, 5'd1, 12'h010, 1'b1, 1'b0, "R7 zero readback");
    do_op(1'b0, 5'd0,  5'd1, 12'h000, 1'b1, 1'b0, "R6 x0 load");
    do_op(1'b0, 5'd9,  5'd1, 12'h000, 1'b1, 1'b0, "R4 odd rd");
    do_op(1'b1, 5'd7,  5'd1, 12'h000, 1'b1, 1'b0, "R4 odd rs2");
    do_op(1'b0, 5'd8,  5'd1, 12'h000, 1'b0, 1'b0, "R3 disabled load");
    do_op(1'b1, 5'd4,  5'd1, 12'h000, 1'b0, 1'b0, "R3 disabled store");
    do_op(1'b0, 5'd8,  5'd3, 12'h000, 1'b1, 1'b0, "R8 misaligned base");
    do_op(1'b0, 5'd8,  5'd1, 12'h002, 1'b1, 1'b0, "R8 misaligned offset");
    do_op(1'b0, 5'd3,  5'd3, 12'h001, 1'b1, 1'b0, "R8 illegal over misaligned");
    do_op(1'b0, 5'd16, 5'd2, 12'h00C, 1'b1, 1'b0, "R9 fault second beat");
    do_op(1'b0, 5'd16, 5'd2, 12'h010, 1'b1, 1'b0, "R9 fault first beat");
    do_op(1'b1, 5'd4,  5'd2, 12'h00C, 1'b1, 1'b0, "R9 store fault second beat");
    do_op(1'b0, 5'd18, 5'd1, 12'h018, 1'b1, 1'b1, "R10 issue while busy");

    // R11: non-paired encodings produce nothing
    drive(7'b0000011, 3'b010, 5'd8, 5'd1, 5'd0, 12'h0, 1'b0);
    settle("R11 word load ignored");
    drive(7'b0110011, 3'b011, 5'd8, 5'd1, 5'd4, 12'h0, 1'b0);
    settle("R11 other opcode ignored");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual run still active expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule